// File: doc/BRIEF.md
# Tick-Driven 8-bit Timer with Compare Output

This peripheral keeps an 8-bit count that advances by one on every cycle in which the `tick` input is high. The enable pulses come from a separate tick source, such as a clock divider. Software sets the block up through a small register port. The registers hold the count, a compare value, a control register, a flag register and an interrupt mask. Writes take effect on the next clock edge. Reads are combinational.

The counter runs in one of two modes:
- **Free-running mode:** the count wraps from 0xFF to 0x00.
- **Clear-on-match mode:** the count returns to zero on the tick after it reaches the compare value, so the period is the compare value plus one ticks.

The block sets an overflow flag and a compare flag. Each flag raises an interrupt line when its mask bit is set. A flag is cleared either by writing one to it or by pulsing its acknowledge input.

A dedicated output pin can toggle, clear or set on each compare match. When no action is selected, the pin carries a general-purpose value instead.

Top module: `cmp_timer8`

## Requirements
- R1: After reset the count, compare value, control, flags, mask, the interrupt lines and the compare pin state are all 0.
- R2: The count is at address 0. With no count write, it rises by one on each cycle where `tick` is high and holds otherwise. In free-running mode it wraps from 0xFF to 0x00.
- R3: A tick while the count is 0xFF sets the overflow flag, which is bit 0 of the flag register at address 3.
- R4: A tick while the count equals the compare register (address 1) is a match and sets the compare flag, which is bit 1 of the flag register.
- R5: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A pulse on `ovf_ack` or `cmp_ack` clears the matching flag.
- R6: `irq_ovf` is the overflow flag AND mask bit 0, and `irq_cmp` is the compare flag AND mask bit 1. The mask register is at address 4.
- R7: The control register is at address 2, with the mode in bits [1:0]. Mode 10 is clear-on-match: a matching tick loads 0, so after k ticks from 0 the count is k mod (compare+1).
- R8: The pin action is in control bits [3:2]. On each match, action 01 toggles the pin state, 10 clears it and 11 sets it.
- R9: With action 00, `cmp_pin` equals `gpio_val`, and the internal pin state is held until an action is selected again.
- R10: A count write wins over a tick in the same cycle and suppresses that cycle's match and overflow.
- R11: When a flag is set by hardware and cleared by write or acknowledge in the same cycle, the flag ends up set.
- R12: Modes 01 and 11 count exactly like mode 00, with no clear on match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational |
| ovf_ack | input | 1 | Overflow interrupt acknowledge |
| cmp_ack | input | 1 | Compare interrupt acknowledge |
| gpio_val | input | 1 | Pin value used when action is 00 |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cmp | output | 1 | Compare interrupt request |
| cmp_pin | output | 1 | Compare output pin |

## Verification
The hardest situations to reach are collisions inside a single cycle:
- a hardware flag set landing in the same cycle as a write-one-to-clear;
- a count preset landing on a tick while the count equals the compare value.

The bench reaches these by first presetting the count to one step before the event. It then raises `tick` and the write strobe together on the same falling edge. Clear-on-match periods are swept over compare values from 0 to 255. The expected count, flag and pin parity are computed from the tick count by modular arithmetic.

// File: rtl/cmp_timer8_pkg.sv
package cmp_timer8_pkg;
    typedef enum logic [1:0] {
        MODE_FREE = 2'b00,
        MODE_PC   = 2'b01,
        MODE_CLR  = 2'b10,
        MODE_FAST = 2'b11
    } tmode_e;

    typedef enum logic [1:0] {
        PIN_OFF = 2'b00,
        PIN_TOG = 2'b01,
        PIN_CLR = 2'b10,
        PIN_SET = 2'b11
    } pact_e;

    localparam int ADDR_W   = 3;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd0;
    localparam logic [ADDR_W-1:0] A_CMP   = 3'd1;
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd2;
    localparam logic [ADDR_W-1:0] A_FLAG  = 3'd3;
    localparam logic [ADDR_W-1:0] A_MASK  = 3'd4;

    localparam int NFLAG   = 2;
    localparam int F_OVF   = 0;
    localparam int F_CMP   = 1;
endpackage

// File: rtl/cmp_timer8_count.sv
module cmp_timer8_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         clr_mode,
    input  logic         wr_cnt,
    input  logic [W-1:0] wr_val,
    input  logic [W-1:0] cmp_val,
    output logic [W-1:0] cnt,
    output logic         ovf_evt,
    output logic         cmp_evt
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
    localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_d, cnt_q;
    logic         at_cmp, adv;

    always_comb begin
        at_cmp  = (cnt_q == cmp_val);
        adv     = tick && !wr_cnt;
        ovf_evt = adv && (cnt_q == CNT_MAX);
        cmp_evt = adv && at_cmp;
        cnt_d   = cnt_q;
        if (wr_cnt) begin
            cnt_d = wr_val;
        end else if (tick) begin
            if (clr_mode && at_cmp) cnt_d = '0;
            else                    cnt_d = cnt_q + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R10
    preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cnt_q == $past(wr_val)));
    // R7
    clr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_cnt && clr_mode && cnt_q == cmp_val) |=> (cnt_q == '0));
    // R2
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_cnt && !(clr_mode && cnt_q == cmp_val))
            |=> ((cnt_q - $past(cnt_q)) == ONE));
    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_cnt) |=> $stable(cnt_q));
endmodule

// File: rtl/cmp_timer8_flags.sv
module cmp_timer8_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_evt,
    input  logic [N-1:0] w1c,
    input  logic [N-1:0] ack,
    input  logic [N-1:0] mask,
    output logic [N-1:0] flag,
    output logic [N-1:0] irq
);
    typedef struct packed {
        logic [N-1:0] flag;
    } fl_t;

    fl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (set_evt[i])            st_d.flag[i] = 1'b1;
            else if (w1c[i] || ack[i]) st_d.flag[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
    assign irq  = st_q.flag & mask;

    for (genvar g = 0; g < N; g++) begin : g_chk
        // R11
        flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_evt[g] |=> st_q.flag[g]);
        // R5
        flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_evt[g] && (w1c[g] || ack[g])) |=> !st_q.flag[g]);
        // R5
        flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_evt[g] && !w1c[g] && !ack[g]) |=> $stable(st_q.flag[g]));
    end
endmodule

// File: rtl/cmp_timer8_pin.sv
module cmp_timer8_pin
    import cmp_timer8_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       match,
    input  logic [1:0] act,
    input  logic       gpio_val,
    output logic       pin
);
    logic pin_d, pin_q;

    always_comb begin
        pin_d = pin_q;
        if (match) begin
            case (pact_e'(act))
                PIN_TOG: pin_d = !pin_q;
                PIN_CLR: pin_d = 1'b0;
                PIN_SET: pin_d = 1'b1;
                default: pin_d = pin_q;
            endcase
        end
        pin = (pact_e'(act) == PIN_OFF) ? gpio_val : pin_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_d;
    end

    // R8
    pin_tog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match && act == PIN_TOG) |=> (pin_q != $past(pin_q)));
    // R8
    pin_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match && act == PIN_CLR) |=> !pin_q);
    // R8
    pin_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match && act == PIN_SET) |=> pin_q);
    // R9
    pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!match || act == PIN_OFF) |=> $stable(pin_q));
endmodule

// File: rtl/cmp_timer8.sv
module cmp_timer8
    import cmp_timer8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [W-1:0]      rd_data,
    input  logic              ovf_ack,
    input  logic              cmp_ack,
    input  logic              gpio_val,
    output logic              irq_ovf,
    output logic              irq_cmp,
    output logic              cmp_pin
);
    typedef struct packed {
        logic [W-1:0]     cmp;
        logic [1:0]       mode;
        logic [1:0]       act;
        logic [NFLAG-1:0] mask;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic             wr_cnt, clr_mode, ovf_evt, cmp_evt;
    logic [W-1:0]     cnt;
    logic [NFLAG-1:0] set_evt, w1c, ack, flag, irq;

    always_comb begin
        cfg_d    = cfg_q;
        wr_cnt   = wr_en && (wr_addr == A_COUNT);
        w1c      = '0;
        if (wr_en) begin
            case (wr_addr)
                A_CMP:  cfg_d.cmp  = wr_data;
                A_CTRL: begin
                    cfg_d.mode = wr_data[1:0];
                    cfg_d.act  = wr_data[3:2];
                end
                A_FLAG: w1c        = wr_data[NFLAG-1:0];
                A_MASK: cfg_d.mask = wr_data[NFLAG-1:0];
                default: ;
            endcase
        end
        clr_mode       = (tmode_e'(cfg_q.mode) == MODE_CLR);
        set_evt        = '0;
        set_evt[F_OVF] = ovf_evt;
        set_evt[F_CMP] = cmp_evt;
        ack            = '0;
        ack[F_OVF]     = ovf_ack;
        ack[F_CMP]     = cmp_ack;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_COUNT: rd_data = cnt;
            A_CMP:   rd_data = cfg_q.cmp;
            A_CTRL:  rd_data[3:0] = {cfg_q.act, cfg_q.mode};
            A_FLAG:  rd_data[NFLAG-1:0] = flag;
            A_MASK:  rd_data[NFLAG-1:0] = cfg_q.mask;
            default: rd_data = '0;
        endcase
    end

    cmp_timer8_count #(.W(W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .clr_mode (clr_mode),
        .wr_cnt   (wr_cnt),
        .wr_val   (wr_data),
        .cmp_val  (cfg_q.cmp),
        .cnt      (cnt),
        .ovf_evt  (ovf_evt),
        .cmp_evt  (cmp_evt)
    );

    cmp_timer8_flags #(.N(NFLAG)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (set_evt),
        .w1c     (w1c),
        .ack     (ack),
        .mask    (cfg_q.mask),
        .flag    (flag),
        .irq     (irq)
    );

    cmp_timer8_pin u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .match    (cmp_evt),
        .act      (cfg_q.act),
        .gpio_val (gpio_val),
        .pin      (cmp_pin)
    );

    assign irq_ovf = irq[F_OVF];
    assign irq_cmp = irq[F_CMP];

    // R3
    ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_cnt && cnt == {W{1'b1}}) |=> flag[F_OVF]);
    // R4
    cmp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_cnt && cnt == cfg_q.cmp) |=> flag[F_CMP]);
endmodule

// File: tb/cmp_timer8_bench.sv
module cmp_timer8_bench;
    localparam int CLK_NS = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       ovf_ack = 1'b0;
    logic       cmp_ack = 1'b0;
    logic       gpio_val = 1'b0;
    logic       irq_ovf, irq_cmp, cmp_pin;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_NS/2) clk = ~clk;

    cmp_timer8 u_cmp_timer8 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .ovf_ack(ovf_ack), .cmp_ack(cmp_ack),
        .gpio_val(gpio_val), .irq_ovf(irq_ovf), .irq_cmp(irq_cmp),
        .cmp_pin(cmp_pin)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_fail++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int v;
        int p0;
        int cv [6] = '{0, 1, 3, 7, 200, 255};
        int nv [4] = '{1, 17, 100, 255};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            chk("R1 reg", v, 0);
        end
        chk("R1 irq_ovf", int'(irq_ovf), 0);
        chk("R1 irq_cmp", int'(irq_cmp), 0);
        wr(3'd2, 8'h04);               // toggle action, to expose pin state
        chk("R1 pin", int'(cmp_pin), 0);
        wr(3'd2, 8'h00);

        // R2 free-running counts, and hold without tick
        foreach (nv[i]) begin
            wr(3'd0, 8'h00);
            ticks(nv[i]);
            rd(3'd0, v);
            chk("R2 count", v, nv[i] % 256);
        end
        repeat (5) @(negedge clk);
        rd(3'd0, v);
        chk("R2 hold", v, 255);

        // R3 overflow on wrap
        wr(3'd3, 8'h03);
        wr(3'd1, 8'h80);
        wr(3'd0, 8'hFD);
        ticks(3);
        rd(3'd0, v);
        chk("R2 wrap", v, 0);
        rd(3'd3, v);
        chk("R3 ovf flag", v & 1, 1);

        // R6 masking
        chk("R6 masked", int'(irq_ovf), 0);
        wr(3'd4, 8'h01);
        chk("R6 ovf irq", int'(irq_ovf), 1);
        chk("R6 cmp irq off", int'(irq_cmp), 0);

        // R5 write 0 no effect, write 1 clears
        wr(3'd3, 8'h00);
        rd(3'd3, v);
        chk("R5 w0 keep", v & 1, 1);
        wr(3'd3, 8'h01);
        rd(3'd3, v);
        chk("R5 w1c", v & 1, 0);
        chk("R6 irq drop", int'(irq_ovf), 0);

        // R4 compare flag and R5 ack
        wr(3'd1, 8'd10);
        wr(3'd0, 8'd8);
        ticks(2);
        rd(3'd3, v);
        chk("R4 before", (v >> 1) & 1, 0);
        ticks(1);
        rd(3'd3, v);
        chk("R4 match", (v >> 1) & 1, 1);
        wr(3'd4, 8'h02);
        chk("R6 cmp irq", int'(irq_cmp), 1);
        @(negedge clk); cmp_ack = 1'b1;
        @(negedge clk); cmp_ack = 1'b0;
        rd(3'd3, v);
        chk("R5 ack", (v >> 1) & 1, 0);
        wr(3'd0, 8'hFF);
        ticks(1);
        @(negedge clk); ovf_ack = 1'b1;
        @(negedge clk); ovf_ack = 1'b0;
        rd(3'd3, v);
        chk("R5 ovf ack", v & 1, 0);

        // R7 + R8 clear-on-match sweep with toggle
        foreach (cv[i]) begin
            int c = cv[i];
            int k = 2 * (c + 1) + c / 2 + 1;
            wr(3'd2, 8'h06);           // toggle, clear-on-match
            wr(3'd1, 8'(c));
            wr(3'd0, 8'h00);
            wr(3'd3, 8'h03);
            p0 = int'(cmp_pin);
            ticks(k);
            rd(3'd0, v);
            chk("R7 count", v, k % (c + 1));
            rd(3'd3, v);
            chk("R4 sweep flag", (v >> 1) & 1, 1);
            chk("R8 toggle", int'(cmp_pin), p0 ^ ((k / (c + 1)) & 1));
        end

        // R8 clear and set actions
        wr(3'd1, 8'd2);
        wr(3'd2, 8'h0A);
        wr(3'd0, 8'h00);
        ticks(3);
        chk("R8 clear", int'(cmp_pin), 0);
        wr(3'd2, 8'h0E);
        ticks(3);
        chk("R8 set", int'(cmp_pin), 1);

        // R9 gpio pass-through, state held
        wr(3'd2, 8'h02);
        gpio_val = 1'b0; #1;
        chk("R9 gpio0", int'(cmp_pin), 0);
        gpio_val = 1'b1; #1;
        chk("R9 gpio1", int'(cmp_pin), 1);
        gpio_val = 1'b0;
        wr(3'd0, 8'h00);
        ticks(6);                      // matches occur, but action is off
        wr(3'd2, 8'h0A);
        chk("R9 held", int'(cmp_pin), 1);

        // R10 write beats tick and suppresses match
        wr(3'd2, 8'h02);
        wr(3'd1, 8'd5);
        wr(3'd0, 8'd5);
        wr(3'd3, 8'h03);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'd9;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        rd(3'd0, v);
        chk("R10 count", v, 9);
        rd(3'd3, v);
        chk("R10 no match", (v >> 1) & 1, 0);

        // R11 set beats clear in same cycle
        wr(3'd0, 8'hFF);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd3; wr_data = 8'h01;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        rd(3'd3, v);
        chk("R11 set wins", v & 1, 1);
        wr(3'd0, 8'd4);
        @(negedge clk);
        tick = 1'b1; cmp_ack = 1'b1;   // count 4 == compare 5? no: 4 -> 5
        @(negedge clk);
        cmp_ack = 1'b0;                // now count 5 == compare, match
        @(negedge clk);
        tick = 1'b0;
        rd(3'd3, v);
        chk("R11 cmp after ack", (v >> 1) & 1, 1);

        // R12 PWM encodings count like free-running
        for (int m = 1; m < 4; m += 2) begin
            wr(3'd2, 8'(m));
            wr(3'd1, 8'd3);
            wr(3'd0, 8'h00);
            ticks(10);
            rd(3'd0, v);
            chk("R12 no clear", v, 10);
        end
        rd(3'd2, v);
        chk("R7 ctrl readback", v, 3);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule